// File: doc/BRIEF.md
# Fill/Copy Blitter Engine

This block moves pixels inside a small framebuffer when a single 32-bit register write asks it to. A write whose address has bit 2 clear only latches a colour word. A write whose address has bit 2 set starts an operation, and that one write carries everything the operation needs. The destination pixel comes from the write address, shifted right by three. The data word supplies a 24-bit source pixel address and a 5-bit length field. A source value of all ones is reserved: it turns the operation into a solid fill with the latched colour. Any other source value makes the operation a forward copy.

The engine owns a single-port 8-bit pixel memory with 2^PIX_AW entries. When the DEEP parameter is set, it also keeps a 24-bit colour plane that mirrors every fill and copy. Fills write one pixel per cycle. Copies take two cycles per pixel, one to read and one to write. While an operation runs, `busy` is high and register writes are stalled. A one-cycle `done` pulse marks the end of each operation. When the engine is idle, a simple view port reads back the stored pixel and plane word at any address.

Top module: `blit_engine`

## Requirements
- R1: An accepted full-word write with address bit 2 clear latches data bits 23:0 as the colour and does not start an operation (`busy` stays low).
- R2: An accepted full-word write with address bit 2 set starts an operation. The destination is address bits [PIX_AW+2:3]. The length is data bits 28:24 plus one, giving 1 to 32 pixels.
- R3: If data bits 23:0 equal 0xFFFFFF, the operation is a fill. Each destination pixel receives colour bits 7:0, and `busy` stays high for exactly `length` cycles.
- R4: Any other source value gives a copy. Pixel source+i is written to destination+i for i from 0 upward, one pixel at a time, so overlapping ranges act as a forward copy. `busy` stays high for 2×`length` cycles.
- R5: The source is data bits [PIX_AW-1:0], and all pixel addresses wrap modulo the memory depth.
- R6: With DEEP set, a fill also writes colour bits 23:0 into the 24-bit plane at each destination, and a copy also copies the plane word.
- R7: Reads return 0, are accepted at once, and start nothing.
- R8: A write without all four byte enables set, or with address bits 1:0 non-zero, is accepted and has no effect.
- R9: While `busy` is high, every write is stalled with `bus_ready` low. The latched colour therefore cannot change during an operation.
- R10: `done` is high for exactly one cycle. That cycle is the first one after the last pixel write, and it is also the first cycle with `busy` low.
- R11: After reset, `busy` and `done` are low and `bus_ready` is high.
- R12: While idle, `view_pix` and `view_rgb` show the pixel and plane word at `view_addr` one cycle after that address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | PIX_AW+3 | Byte address within the window |
| bus_be | input | 4 | Byte enables; only 4'hF is acted on |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted this cycle |
| bus_rdata | output | 32 | Read data, always zero |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| view_addr | input | PIX_AW | Pixel address to display |
| view_pix | output | 8 | Pixel at view_addr, one cycle later |
| view_rgb | output | 24 | Plane word at view_addr (zero when DEEP is 0) |

## Verification
The bench sweeps fill and copy lengths from 1 to 32 at destinations that wrap past the end of memory. A design with an off-by-one length or missing address wrap would corrupt a neighbouring pixel, or fail to write the last one. Overlapping copies in both directions are included. A design that buffered the source, or copied backwards, would not show the forward replication pattern that an overlap with the destination ahead of the source produces. The bench also issues partial and misaligned writes, reads, and a colour write stalled behind a running fill. An engine that let such accesses through would change pixels, start spurious operations, or change the fill colour part-way through.

// File: rtl/blit_engine.sv
module blit_engine #(
  parameter int PIX_AW = 10,
  parameter bit DEEP   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [PIX_AW+2:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ready,
  output logic [31:0]       bus_rdata,
  output logic              busy,
  output logic              done,
  input  logic [PIX_AW-1:0] view_addr,
  output logic [7:0]        view_pix,
  output logic [23:0]       view_rgb
);
  localparam int DEPTH = 1 << PIX_AW;
  localparam logic [23:0] FILL_CODE = 24'hFFFFFF;

  logic [23:0]       colour_q;
  logic              fill_q, phase_q;
  logic [4:0]        left_q;
  logic [PIX_AW-1:0] dst_q, src_q, port_a;
  logic [7:0]        pix_mem [DEPTH];
  logic [7:0]        pix_q;

  wire full_word = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
  wire take      = bus_valid && bus_ready && bus_write && full_word;
  wire launch    = take && bus_addr[2];
  wire wr_now    = busy && (fill_q || phase_q);
  wire last      = wr_now && (left_q == 5'd0);
  wire unused_hi = ^bus_wdata[31:29];

  assign bus_ready = !(busy && bus_write);
  assign bus_rdata = '0;
  assign port_a    = !busy ? view_addr : ((!fill_q && !phase_q) ? src_q : dst_q);
  assign view_pix  = pix_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      colour_q <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      fill_q   <= 1'b0;
      phase_q  <= 1'b0;
      left_q   <= '0;
      dst_q    <= '0;
      src_q    <= '0;
    end else begin
      done <= last;
      if (take && !bus_addr[2]) colour_q <= bus_wdata[23:0];
      if (launch) begin
        busy    <= 1'b1;
        fill_q  <= (bus_wdata[23:0] == FILL_CODE);
        phase_q <= 1'b0;
        left_q  <= bus_wdata[28:24];
        dst_q   <= bus_addr[PIX_AW+2:3];
        src_q   <= bus_wdata[PIX_AW-1:0];
      end else if (busy) begin
        if (!fill_q) phase_q <= !phase_q;
        if (wr_now) begin
          dst_q  <= dst_q + 1'b1;
          src_q  <= src_q + 1'b1;
          left_q <= left_q - 1'b1;
          if (left_q == 5'd0) busy <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_now) pix_mem[dst_q] <= fill_q ? colour_q[7:0] : pix_q;
    pix_q <= pix_mem[port_a];
  end

  generate
    if (DEEP) begin : g_plane
      logic [23:0] plane_mem [DEPTH];
      logic [23:0] rgb_q;
      always_ff @(posedge clk) begin
        if (wr_now) plane_mem[dst_q] <= fill_q ? colour_q : rgb_q;
        rgb_q <= plane_mem[port_a];
      end
      assign view_rgb = rgb_q;
    end else begin : g_flat
      wire unused_col = ^colour_q[23:8];
      assign view_rgb = '0;
    end
  endgenerate

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy && (left_q == $past(bus_wdata[28:24])))
    else $error("launch did not start the engine");
  assert_colour_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take && !bus_addr[2] && !busy |=> !busy)
    else $error("colour write started an operation");
  assert_read_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && !busy |=> !busy)
    else $error("read started an operation");
  assert_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_ready && !full_word |=> !busy && $stable(colour_q))
    else $error("partial access had an effect");
  assert_colour_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(colour_q))
    else $error("colour changed during an operation");
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");
  assert_done_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy))
    else $error("done without a finished operation");
endmodule

// File: tb/test_blit_engine.sv
`timescale 1ns/1ps
module test_blit_engine;
  localparam int AW = 8;
  localparam int N  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW+2:0] bus_addr = '0;
  logic [3:0] bus_be = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, busy, done;
  logic [31:0] bus_rdata;
  logic [AW-1:0] view_addr = '0;
  logic [7:0] view_pix;
  logic [23:0] view_rgb;

  int vectors = 0, errors = 0;
  logic [7:0]  e8  [N];
  logic [23:0] e24 [N];
  logic [23:0] ecol = '0;

  always #2.5 clk = ~clk;

  blit_engine #(.PIX_AW(AW), .DEEP(1'b1)) i_blit_engine (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .busy(busy), .done(done),
    .view_addr(view_addr), .view_pix(view_pix), .view_rgb(view_rgb));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW+2:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic compare_all(input string tag);
    for (int a = 0; a < N; a++) begin
      view_addr = a[AW-1:0];
      @(negedge clk);
      chk(view_pix == e8[a], tag, view_pix, e8[a]);
      chk(view_rgb == e24[a], "R6", view_rgb, e24[a]);
    end
  endtask

  task automatic run_op(input int dst, input logic [23:0] src, input int len, input string tag);
    int n = 0;
    bit is_fill = (src == 24'hFFFFFF);
    for (int i = 0; i < len; i++) begin
      int d = (dst + i) % N;
      int s = (src + i) % N;
      if (is_fill) begin e8[d] = ecol[7:0]; e24[d] = ecol; end
      else begin e8[d] = e8[s]; e24[d] = e24[s]; end
    end
    bus_wr({dst[AW-1:0], 3'b100}, {3'b000, 5'(len - 1), src}, 4'hF);
    while (busy) begin n++; @(negedge clk); end
    chk(n == (is_fill ? len : 2 * len), is_fill ? "R3 busy length" : "R4 busy length",
        n, is_fill ? len : 2 * len);
    chk(done == 1'b1, "R10 done high", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R10 done single", done, 0);
    compare_all(tag);
  endtask

  task automatic set_colour(input logic [31:0] c);
    bus_wr(11'b000, c, 4'hF);
    ecol = c[23:0];
    chk(busy == 1'b0, "R1 no start", busy, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R11 busy", busy, 0);
    chk(done == 1'b0, "R11 done", done, 0);
    chk(bus_ready == 1'b1, "R11 ready", bus_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 11'b100; bus_be = 4'hF;
    chk(bus_ready == 1'b1, "R7 read ready", bus_ready, 1);
    chk(bus_rdata == 32'h0, "R7 read zero", bus_rdata, 0);
    @(negedge clk);
    bus_valid = 1'b0;
    chk(busy == 1'b0, "R7 read no start", busy, 0);

    for (int k = 0; k < N / 32; k++) begin
      set_colour(32'hAB000000 | (32'h010203 * (k + 1)));
      run_op(k * 32, 24'hFFFFFF, 32, "R3 init fill R12");
    end

    for (int len = 1; len <= 32; len++) begin
      set_colour({8'h5A, 8'(len * 3), 8'(len * 11), 8'(len * 29 + 1)});
      run_op((len * 37) % N, 24'hFFFFFF, len, "R3 R5 fill sweep");
    end

    for (int len = 1; len <= 32; len++)
      run_op((len * 53 + 7) % N, 24'((len * 91) + 24'h100 * len), len, "R4 R5 copy sweep");

    run_op(12, 24'd10, 20, "R4 overlap forward");
    run_op(35, 24'd40, 20, "R4 overlap backward");
    run_op(250, 24'hFFFFFE, 12, "R5 wrap both");

    set_colour(32'h00112233);
    bus_wr(11'b000, 32'h00AABBCC, 4'h7);
    run_op(100, 24'hFFFFFF, 3, "R8 partial colour ignored");
    bus_wr({8'd120, 3'b100}, {3'b000, 5'd4, 24'hFFFFFF}, 4'hE);
    chk(busy == 1'b0, "R8 partial launch", busy, 0);
    bus_wr({8'd120, 3'b101}, {3'b000, 5'd4, 24'hFFFFFF}, 4'hF);
    chk(busy == 1'b0, "R8 misaligned launch", busy, 0);
    compare_all("R8 memory untouched");

    begin : stall
      int lows = 0;
      set_colour(32'h00445566);
      for (int i = 0; i < 20; i++) begin e8[(60 + i) % N] = 8'h66; e24[(60 + i) % N] = 24'h445566; end
      bus_wr({8'd60, 3'b100}, {3'b000, 5'd19, 24'hFFFFFF}, 4'hF);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 11'b000; bus_wdata = 32'h00778899; bus_be = 4'hF;
      while (!bus_ready) begin lows++; @(negedge clk); end
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      chk(lows == 20, "R9 stall cycles", lows, 20);
      ecol = 24'h778899;
      compare_all("R9 colour held");
      run_op(200, 24'hFFFFFF, 5, "R9 new colour after");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule